// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches two external interrupt pins of a small microcontroller and turns their activity into a single interrupt request toward the CPU core, together with the program address of the matching handler. Each pin is first passed through a two-flop synchroniser. A 2-bit sense code then selects how the pin is judged: low level, any edge, falling edge or rising edge. In the three edge modes an event sets a per-pin flag that stays set until software writes a one to it or the core acknowledges that vector. In low-level mode no flag is kept. The request follows the synchronised pin and is lost once the pin returns high. The pin value alone drives the logic. There is no pin-direction input, so a pin that the chip drives as an output still raises requests.

Software reaches two byte registers through a small I/O port: an enable register at address 0x3B and a flag register at address 0x3A. A pin's request is pending when the global interrupt-enable input, the pin's enable bit and the pin's flag (or its active low level) are all set.

A three-state presentation machine picks one pending source and shows it on the request and vector outputs:

- **States:** IDLE (nothing shown), SHOW0 (pin 0 shown, vector 0x002) and SHOW1 (pin 1 shown, vector 0x004).
- **Leaving IDLE:**
  - *take0*: IDLE to SHOW0 when pin 0 is pending.
  - *take1*: IDLE to SHOW1 when only pin 1 is pending.
- **Leaving a SHOW state:**
  - *ack*: SHOW0 or SHOW1 to IDLE when the core acknowledges.
  - *drop*: SHOW0 or SHOW1 to IDLE when the shown source stops being pending. For SHOW1 this applies only when pin 0 is not pending either.
  - *preempt*: SHOW1 to SHOW0 when pin 0 becomes pending before pin 1 is acknowledged.
- **Staying:**
  - *hold*: a SHOW state keeps itself while its source stays pending and no acknowledge arrives.
  - *wait*: IDLE keeps itself while nothing is pending.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The enable register at I/O address 0x3B holds the pin 1 enable in bit 7 and the pin 0 enable in bit 6. Bits 5..0 read as 0 and ignore writes. Both enables reset to 0, and a write to that address loads bits 7..6 from the write data.
- R2: The flag register at I/O address 0x3A shows the pin 1 flag in bit 7 and the pin 0 flag in bit 6, with bits 5..0 reading 0. Both flags reset to 0. Any other address reads 0x00. Reads are combinational from the address input.
- R3: Sense code per pin is taken from sense_i ([1:0] for pin 0, [3:2] for pin 1). The codes are 00 low level, 01 any edge, 10 falling edge and 11 rising edge. In an edge mode, the pin change that first meets the synchroniser at a rising clock edge sets the flag at the third rising edge counted from that one. The synchroniser resets to the high level.
- R4: Writing to 0x3A with a one in a flag's bit position clears that flag. A zero there leaves it unchanged. An edge event arriving in the same cycle as a clear wins, and the flag stays set.
- R5: In low-level mode the flag is held at 0. The request is pending only while the synchronised pin is low and is not remembered afterwards.
- R6: A pin is pending only when gie_i, its enable bit and its flag (or in low-level mode its low pin) are all 1. irq_o rises one clock edge after a source becomes pending, and it is 0 whenever nothing was pending at the previous edge.
- R7: irq_vec_o reads 0x002 while pin 0 is shown, 0x004 while pin 1 is shown, and 0x000 when irq_o is 0.
- R8: When both pins are pending, pin 0 is shown first. A pin 0 source that becomes pending while pin 1 is shown and not yet acknowledged replaces it at the next edge.
- R9: irq_ack_i while a pin is shown clears that pin's flag and returns to IDLE for at least one cycle. irq_ack_i in IDLE changes no flag.
- R10: If the shown source stops being pending without an acknowledge, irq_o falls at the next edge. This happens when gie_i or its enable goes low, its flag is cleared, or its low level ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw external pins; bit 0 is pin 0 |
| sense_i | input | 4 | Sense codes: [1:0] pin 0, [3:2] pin 1 |
| gie_i | input | 1 | Global interrupt enable from the core |
| io_addr_i | input | 6 | I/O register address |
| io_wr_i | input | 1 | Write strobe for io_addr_i |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for io_addr_i |
| irq_ack_i | input | 1 | Core has taken the shown vector |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 13 | Handler program address |

## Verification
The embedded properties watch, on every cycle, several rules:
- Low-level mode keeps the flag cleared.
- An unchallenged flag survives a write of zero.
- An acknowledge clears the shown flag and forces IDLE.
- Pin 0 never loses to pin 1.
- Nothing is shown without a pending source.
- The vector is zero in IDLE.
- The enable register moves only on its own write.

Only the bench's scenarios can show the end-to-end latency through the synchroniser and the edge detector for each sense code. They also cover the register read layout, an edge colliding with a clear, and a level request vanishing when the pin returns high. These are followed cycle by cycle against a bench-side reference across directed and random stimulus.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-pin sense selection
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    // Presentation machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHOW0 = 2'b01,
        ST_SHOW1 = 2'b10
    } show_state_e;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_e mode_i,
    input  logic   gie_i,
    input  logic   en_i,
    input  logic   clr_wr_i,
    input  logic   clr_ack_i,
    output logic   flag_o,
    output logic   pend_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   prev_q;
    logic                   evt;
    logic                   flag_q;
    logic                   flag_d;

    // Synchroniser, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= pin_s;
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (mode_i)
            SNS_ANY:  evt = pin_s ^ prev_q;
            SNS_FALL: evt = prev_q & ~pin_s;
            SNS_RISE: evt = ~prev_q & pin_s;
            default:  evt = 1'b0;
        endcase
    end

    // Flag: event beats any clear; level mode holds it low
    always_comb begin
        flag_d = flag_q;
        if (mode_i == SNS_LOW) begin
            flag_d = 1'b0;
        end else begin
            if (clr_wr_i || clr_ack_i) flag_d = 1'b0;
            if (evt) flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign pend_o = gie_i & en_i & ((mode_i == SNS_LOW) ? ~pin_s : flag_q);

    // R5: level mode keeps the flag cleared
    a_r5_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_LOW) |=> !flag_q);

    // R3: an edge event in an edge mode sets the flag
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_i != SNS_LOW) |=> flag_q);

    // R4: without a clear the flag survives
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr_i && !clr_ack_i && mode_i != SNS_LOW) |=> flag_q);

    // R9: acknowledge clears the flag unless a new event arrives
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ack_i && !evt) |=> !flag_q);

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int               ADDR_W    = 6,
    parameter int               DATA_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [NUM_SRC-1:0]  wbits_i,
    input  logic [NUM_SRC-1:0]  flag_i,
    output logic [NUM_SRC-1:0]  en_o,
    output logic [NUM_SRC-1:0]  flag_clr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    localparam int BIT_LSB = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] en_q;
    logic               mask_sel;
    logic               flag_sel;

    assign mask_sel = (addr_i == MASK_ADDR);
    assign flag_sel = (addr_i == FLAG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                en_q <= '0;
        else if (wr_i && mask_sel) en_q <= wbits_i;
    end

    assign en_o       = en_q;
    assign flag_clr_o = (wr_i && flag_sel) ? wbits_i : '0;

    always_comb begin
        rdata_o = '0;
        if (mask_sel)      rdata_o[BIT_LSB +: NUM_SRC] = en_q;
        else if (flag_sel) rdata_o[BIT_LSB +: NUM_SRC] = flag_i;
    end

    // R1: enables change only on a write to their address
    a_r1_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && mask_sel) |=> $stable(en_q));

endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
    import ext_irq_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  pend_i,
    input  logic                ack_i,
    output logic                irq_o,
    output logic [PC_W-1:0]     vec_o,
    output logic [NUM_SRC-1:0]  ack_clr_o
);

    localparam logic [PC_W-1:0] VEC0 = PC_W'(VEC_BASE);
    localparam logic [PC_W-1:0] VEC1 = PC_W'(VEC_BASE + VEC_STEP);

    show_state_e state_q;
    show_state_e state_d;

    // Next-state: take0/take1, ack, drop, preempt, hold, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_i[0])      state_d = ST_SHOW0;
                else if (pend_i[1]) state_d = ST_SHOW1;
            end
            ST_SHOW0: begin
                if (ack_i || !pend_i[0]) state_d = ST_IDLE;
            end
            ST_SHOW1: begin
                if (ack_i)          state_d = ST_IDLE;
                else if (pend_i[0]) state_d = ST_SHOW0;
                else if (!pend_i[1]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state register
    always_comb begin
        irq_o     = 1'b0;
        vec_o     = '0;
        ack_clr_o = '0;
        unique case (state_q)
            ST_SHOW0: begin
                irq_o        = 1'b1;
                vec_o        = VEC0;
                ack_clr_o[0] = ack_i;
            end
            ST_SHOW1: begin
                irq_o        = 1'b1;
                vec_o        = VEC1;
                ack_clr_o[1] = ack_i;
            end
            default: ;
        endcase
    end

    // R6: nothing pending means IDLE next
    a_r6_no_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);

    // R8: pin 0 pending never leads to pin 1 being shown
    a_r8_pin0_first: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i[0] |=> (state_q != ST_SHOW1));

    // R9: an acknowledge while shown returns to IDLE
    a_r9_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (state_q == ST_IDLE));

    // R7: vector is zero whenever no request is shown
    a_r7_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 6,
    parameter int                DATA_W      = 8,
    parameter int                PC_W        = 13,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 6'h3B,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 6'h3A,
    parameter int                VEC_BASE    = 2,
    parameter int                VEC_STEP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pin_i,
    input  logic [3:0]        sense_i,
    input  logic              gie_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_wr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    output logic [DATA_W-1:0] io_rdata_o,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic [PC_W-1:0]   irq_vec_o
);

    localparam int BIT_LSB = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] flag;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr_wr;
    logic [NUM_SRC-1:0] clr_ack;
    logic [BIT_LSB-1:0] wdata_unused;

    assign wdata_unused = io_wdata_i[BIT_LSB-1:0];

    ext_irq_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MASK_ADDR (MASK_ADDR),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (io_addr_i),
        .wr_i       (io_wr_i),
        .wbits_i    (io_wdata_i[BIT_LSB +: NUM_SRC]),
        .flag_i     (flag),
        .en_o       (en),
        .flag_clr_o (clr_wr),
        .rdata_o    (io_rdata_o)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        ext_irq_sense #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_i[g]),
            .mode_i    (sense_e'(sense_i[2*g +: 2])),
            .gie_i     (gie_i),
            .en_i      (en[g]),
            .clr_wr_i  (clr_wr[g]),
            .clr_ack_i (clr_ack[g]),
            .flag_o    (flag[g]),
            .pend_o    (pend[g])
        );
    end

    ext_irq_arb #(
        .PC_W     (PC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .ack_i     (irq_ack_i),
        .irq_o     (irq_o),
        .vec_o     (irq_vec_o),
        .ack_clr_o (clr_ack)
    );

    // R10: a request falls once global enable was low
    a_r10_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !irq_o);

endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin_i = 2'b11;
    logic [3:0]  sense_i = 4'b0000;
    logic        gie_i = 1'b0;
    logic [5:0]  io_addr_i = 6'h3B;
    logic        io_wr_i = 1'b0;
    logic [7:0]  io_wdata_i = 8'h00;
    logic [7:0]  io_rdata_o;
    logic        irq_ack_i = 1'b0;
    logic        irq_o;
    logic [12:0] irq_vec_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference state
    logic [1:0] m_s1 = 2'b11;
    logic [1:0] m_s2 = 2'b11;
    logic [1:0] m_prev = 2'b11;
    logic [1:0] m_en = 2'b00;
    logic [1:0] m_flag = 2'b00;
    int         m_st = 0;   // 0 idle, 1 pin 0 shown, 2 pin 1 shown

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .sense_i    (sense_i),
        .gie_i      (gie_i),
        .io_addr_i  (io_addr_i),
        .io_wr_i    (io_wr_i),
        .io_wdata_i (io_wdata_i),
        .io_rdata_o (io_rdata_o),
        .irq_ack_i  (irq_ack_i),
        .irq_o      (irq_o),
        .irq_vec_o  (irq_vec_o)
    );

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        if (a == 6'h3B)      return {m_en, 6'b0};
        else if (a == 6'h3A) return {m_flag, 6'b0};
        else                 return 8'h00;
    endfunction

    function automatic logic [12:0] exp_vec();
        if (m_st == 1)      return 13'h002;
        else if (m_st == 2) return 13'h004;
        else                return 13'h000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R6/R8/R10 irq_o", 32'(irq_o), 32'(m_st != 0));
        check("R7 irq_vec_o", 32'(irq_vec_o), 32'(exp_vec()));
        check("R1/R2/R3/R4/R5/R9 io_rdata_o", 32'(io_rdata_o), 32'(exp_rd(io_addr_i)));
    endtask

    // One clock: reference steps from pre-edge inputs, then compare at negedge
    task automatic tick();
        logic [1:0] evt, pend, nflag, clrw, clra;
        int nst;
        for (int i = 0; i < 2; i++) begin
            logic [1:0] md;
            md = sense_i[2*i +: 2];
            case (md)
                2'b01:   evt[i] = m_s2[i] ^ m_prev[i];
                2'b10:   evt[i] = m_prev[i] & ~m_s2[i];
                2'b11:   evt[i] = ~m_prev[i] & m_s2[i];
                default: evt[i] = 1'b0;
            endcase
            pend[i] = gie_i & m_en[i] & ((md == 2'b00) ? ~m_s2[i] : m_flag[i]);
            clrw[i] = io_wr_i && (io_addr_i == 6'h3A) && io_wdata_i[6+i];
            clra[i] = irq_ack_i && (m_st == i + 1);
            if (md == 2'b00) nflag[i] = 1'b0;
            else             nflag[i] = ((clrw[i] | clra[i]) ? 1'b0 : m_flag[i]) | evt[i];
        end
        nst = m_st;
        case (m_st)
            0: nst = pend[0] ? 1 : (pend[1] ? 2 : 0);
            1: nst = (irq_ack_i || !pend[0]) ? 0 : 1;
            default: nst = irq_ack_i ? 0 : (pend[0] ? 1 : (pend[1] ? 2 : 0));
        endcase
        @(posedge clk);
        if (io_wr_i && io_addr_i == 6'h3B) m_en = io_wdata_i[7:6];
        m_flag = nflag;
        m_st   = nst;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin_i;
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
        tick();
        io_wr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2 reset values
        io_addr_i = 6'h3B; #1;
        check("R1 enable reset", 32'(io_rdata_o), 32'h00);
        io_addr_i = 6'h3A; #1;
        check("R2 flag reset", 32'(io_rdata_o), 32'h00);
        check("R6 irq reset", 32'(irq_o), 32'h0);

        // R1: write all ones, only bits 7..6 kept
        io_write(6'h3B, 8'hFF);
        io_addr_i = 6'h3B; #1;
        check("R1 enable layout", 32'(io_rdata_o), 32'hC0);
        io_addr_i = 6'h10; #1;
        check("R2 other address", 32'(io_rdata_o), 32'h00);

        // R3: falling edge on pin 0, latency through sync and detector
        sense_i = 4'b1110;   // pin1 rise, pin0 fall
        gie_i = 1'b1;
        io_addr_i = 6'h3A;
        pin_i[0] = 1'b0;
        ticks(2);
        check("R3 flag not yet", 32'(io_rdata_o), 32'h00);
        tick();
        check("R3 flag set third edge", 32'(io_rdata_o), 32'h40);
        check("R6 irq one edge later", 32'(irq_o), 32'h0);
        tick();
        check("R6 irq raised", 32'(irq_o), 32'h1);
        check("R7 vector pin0", 32'(irq_vec_o), 32'h002);

        // R4: zero in bit 6 leaves flag 0
        io_write(6'h3A, 8'h80);
        io_addr_i = 6'h3A; #1;
        check("R4 zero keeps flag", 32'(io_rdata_o), 32'h40);
        // R9: acknowledge clears and returns to idle
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0; #1;
        check("R9 ack clears flag", 32'(io_rdata_o), 32'h00);
        check("R9 ack idle", 32'(irq_o), 32'h0);

        // R8: both pending, pin 0 first
        gie_i = 1'b0;
        pin_i[1] = 1'b0;
        ticks(4);
        sense_i = 4'b1101;   // pin1 rise, pin0 any
        pin_i = 2'b11;
        ticks(4);
        check("R8 both flags", 32'(io_rdata_o), 32'hC0);
        check("R6 gie low no irq", 32'(irq_o), 32'h0);
        gie_i = 1'b1;
        tick();
        check("R8 pin0 first", 32'(irq_vec_o), 32'h002);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
        check("R9 idle after ack", 32'(irq_o), 32'h0);
        tick();
        check("R8 pin1 next", 32'(irq_vec_o), 32'h004);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0; #1;
        check("R9 flags clear", 32'(io_rdata_o), 32'h00);

        // R5: level mode on pin 1
        sense_i = 4'b0001;
        pin_i[1] = 1'b0;
        ticks(2);
        check("R5 level not yet", 32'(irq_o), 32'h0);
        tick();
        check("R5 level request", 32'(irq_vec_o), 32'h004);
        pin_i[1] = 1'b1;
        ticks(2);
        check("R10 still shown", 32'(irq_o), 32'h1);
        tick();
        check("R10 level gone", 32'(irq_o), 32'h0);
        check("R5 no level flag", 32'(io_rdata_o), 32'h00);

        // R9: ack in idle ignored; R6 disabled pin no request
        io_write(6'h3B, 8'h80);
        io_addr_i = 6'h3A;
        pin_i[0] = 1'b0;
        ticks(4);
        check("R6 disabled no irq", 32'(irq_o), 32'h0);
        irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0; #1;
        check("R9 idle ack ignored", 32'(io_rdata_o), 32'h40);

        // Random phase checked against the reference every cycle
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 5));
            if (r == 0) pin_i[0] = ~pin_i[0];
            if ($urandom_range(0, 5) == 0) pin_i[1] = ~pin_i[1];
            if ($urandom_range(0, 39) == 0) sense_i = 4'($urandom);
            gie_i = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 2))
                0: io_addr_i = 6'h3A;
                1: io_addr_i = 6'h3B;
                default: io_addr_i = 6'h10;
            endcase
            io_wr_i = ($urandom_range(0, 7) == 0);
            io_wdata_i = 8'($urandom);
            irq_ack_i = (m_st != 0) ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 9) == 0);
            tick();
        end
        io_wr_i = 1'b0;
        irq_ack_i = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule